// File: doc/BRIEF.md
# Interrupt Acceptance and Flag Unit

This block holds the processor's 16-bit flag word and decides, at each instruction boundary, whether an interrupt is taken and which one. Three hardware sources compete: a non-maskable pin that triggers on a falling edge, a single-step trap armed by the debug flag, and a maskable request that carries a 3-bit priority. When one of them wins, the block emits a one-cycle take strobe with a source code and applies the flag changes that acceptance implies. Instruction sequencing, vector table reads and stack pushes are handled elsewhere.

A maskable request may be marked high-speed. In that case the flag word and the current 24-bit program counter are copied into dedicated save registers, and the jump target comes from a vector register rather than from memory. A restore strobe reloads the flag word from its save register in one cycle and presents the saved program counter, so the return path never touches the stack. The datapath writes the flag word directly, and software interrupt instructions report their number so that the stack-select flag can be cleared.

Top module: `intr_accept_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the flag word, save registers, jump address, restore address and all strobes become zero.
- R2: Flag bit positions are carry 0, debug 1, zero 2, sign 3, bank 4, overflow 5, interrupt enable 6, stack select 7, priority level 14:12. Bits 11:8 and 15 always read 0. A datapath write (`flg_we`) stores `flg_wdata` with the reserved bits cleared.
- R3: A maskable request is taken only at an instruction boundary (`instr_end`=1), only when the interrupt enable flag is 1, and only when `irq_lvl` is strictly greater than the priority level field.
- R4: Every take raises `take_o` for one cycle and clears the interrupt enable and stack select flags in the same cycle. All other flag bits are left as they were. `take_kind_o` is 1 for maskable, 2 for single-step and 3 for the pin source.
- R5: With the debug flag at 1, a boundary causes a single-step take, and that take also clears the debug flag.
- R6: A high-to-low transition on `nmi_pin` passes through a two-flop synchroniser and becomes pending three clock edges after the pin changes. It is taken at the next boundary whatever the flag values are, stays pending until it is taken, and a rising edge raises nothing.
- R7: When several sources are ready at the same boundary, the pin source beats single-step, and single-step beats a maskable request.
- R8: A software interrupt strobe clears the stack select flag when `swi_num` is below 32 and leaves it unchanged for numbers 32 and above. No other flag bit changes.
- R9: A taken maskable request with `irq_fast`=1 raises `fast_o`. It copies the flag word as it stood before the take into `svf_o` and `pc_in` into `svp_o`, and loads `jump_o` with the vector register as it stood before that edge. The vector register is written by `vct_we`.
- R10: `restore` reloads the flag word from `svf_o`, raises `pc_load_o` for one cycle with `pc_load_addr_o` equal to `svp_o`, and blocks any take in that cycle.
- R11: A take outranks a software interrupt strobe and a datapath write in the same cycle, and such a write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_end | input | 1 | Instruction boundary, acceptance point |
| irq_req | input | 1 | Maskable request pending |
| irq_lvl | input | 3 | Priority of the maskable request |
| irq_fast | input | 1 | Maskable request uses the high-speed path |
| nmi_pin | input | 1 | Non-maskable pin, asynchronous, falling edge |
| swi_take | input | 1 | Software interrupt instruction executes |
| swi_num | input | 6 | Software interrupt number |
| flg_we | input | 1 | Datapath flag write |
| flg_wdata | input | 16 | Datapath flag write value |
| pc_in | input | 24 | Current program counter |
| vct_we | input | 1 | Vector register write |
| vct_wdata | input | 24 | Vector register write value |
| restore | input | 1 | Fast return: reload flag word and PC |
| flg_o | output | 16 | Flag word |
| take_o | output | 1 | Interrupt taken strobe |
| take_kind_o | output | 2 | Source of the take (1 maskable, 2 step, 3 pin) |
| fast_o | output | 1 | High-speed take strobe |
| jump_o | output | 24 | Jump address of the last high-speed take |
| svf_o | output | 16 | Flag save register |
| svp_o | output | 24 | PC save register |
| pc_load_o | output | 1 | PC reload strobe on restore |
| pc_load_addr_o | output | 24 | PC value for the reload |

## Verification
Directed cases place the request priority equal to and one above the level field, with the enable flag both set and cleared, so that the strict comparison and the enable gate are tested separately. Stacked cases present the pin source, the debug flag and a qualifying request at the same boundary, and then repeat the boundary, which shows the precedence order and the clearing of the pending state. Software numbers 31 and 32 bracket the stack-select limit. A take that coincides with a flag write checks which update wins. A long constrained-random run mixes writes, requests, software strobes, vector loads and restores in every combination, and a model of the flag rules checks all outputs on each cycle.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int FLG_W   = 16;
  localparam int PC_W    = 24;
  localparam int IPL_W   = 3;
  localparam int SWI_W   = 6;
  localparam int SWI_LIM = 32;
  localparam int SYNC_N  = 2;

  localparam int B_CARRY = 0;
  localparam int B_DBG   = 1;
  localparam int B_ZERO  = 2;
  localparam int B_SIGN  = 3;
  localparam int B_BANK  = 4;
  localparam int B_OVF   = 5;
  localparam int B_IEN   = 6;
  localparam int B_USP   = 7;
  localparam int B_IPL   = 12;

  localparam logic [FLG_W-1:0] RSV_MASK = 16'h8F00;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MASK = 2'd1,
    SRC_STEP = 2'd2,
    SRC_NMI  = 2'd3
  } src_e;
endpackage

// File: rtl/nmi_edge_det.sv
module nmi_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic clr,
  output logic pend
);
  // sh[0..STAGES-1] synchronise; sh[STAGES] holds the previous synced value
  logic [STAGES:0] sh;
  logic            fall;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= fall | (pend & ~clr);
  end

  // R6: a pending event is never dropped before it is consumed
  assert_nmi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    pend && !clr |=> pend);
endmodule

// File: rtl/take_arbiter.sv
module take_arbiter
  import intr_pkg::*;
(
  input  logic             instr_end,
  input  logic             hold,
  input  logic             nmi_pend,
  input  logic             dbg,
  input  logic             ien,
  input  logic [IPL_W-1:0] ipl,
  input  logic             irq_req,
  input  logic [IPL_W-1:0] irq_lvl,
  input  logic             irq_fast,
  output src_e             src,
  output logic             fast
);
  logic boundary;
  logic mask_ok;

  assign boundary = instr_end & ~hold;
  assign mask_ok  = irq_req & ien & (irq_lvl > ipl);

  always_comb begin
    src  = SRC_NONE;
    fast = 1'b0;
    if (boundary) begin
      if (nmi_pend)     src = SRC_NMI;
      else if (dbg)     src = SRC_STEP;
      else if (mask_ok) begin
        src  = SRC_MASK;
        fast = irq_fast;
      end
    end
  end
endmodule

// File: rtl/save_bank.sv
module save_bank
  import intr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             save_en,
  input  logic [FLG_W-1:0] flg_in,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             vct_we,
  input  logic [PC_W-1:0]  vct_in,
  output logic [FLG_W-1:0] svf,
  output logic [PC_W-1:0]  svp,
  output logic [PC_W-1:0]  vct
);
  always_ff @(posedge clk) begin
    if (rst) begin
      svf <= '0;
      svp <= '0;
      vct <= '0;
    end else begin
      if (save_en) begin
        svf <= flg_in;
        svp <= pc_in;
      end
      if (vct_we) vct <= vct_in;
    end
  end
endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
  import intr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_end,
  input  logic             irq_req,
  input  logic [IPL_W-1:0] irq_lvl,
  input  logic             irq_fast,
  input  logic             nmi_pin,
  input  logic             swi_take,
  input  logic [SWI_W-1:0] swi_num,
  input  logic             flg_we,
  input  logic [FLG_W-1:0] flg_wdata,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             vct_we,
  input  logic [PC_W-1:0]  vct_wdata,
  input  logic             restore,
  output logic [FLG_W-1:0] flg_o,
  output logic             take_o,
  output logic [1:0]       take_kind_o,
  output logic             fast_o,
  output logic [PC_W-1:0]  jump_o,
  output logic [FLG_W-1:0] svf_o,
  output logic [PC_W-1:0]  svp_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_load_addr_o
);
  logic [FLG_W-1:0] flg_q, flg_d;
  logic             nmi_pend;
  src_e             src;
  logic             fast;
  logic             take;
  logic [PC_W-1:0]  vct;

  nmi_edge_det #(.STAGES(SYNC_N)) u_nmi (
    .clk (clk),
    .rst (rst),
    .pin (nmi_pin),
    .clr (src == SRC_NMI),
    .pend(nmi_pend)
  );

  take_arbiter u_arb (
    .instr_end(instr_end),
    .hold     (restore),
    .nmi_pend (nmi_pend),
    .dbg      (flg_q[B_DBG]),
    .ien      (flg_q[B_IEN]),
    .ipl      (flg_q[B_IPL +: IPL_W]),
    .irq_req  (irq_req),
    .irq_lvl  (irq_lvl),
    .irq_fast (irq_fast),
    .src      (src),
    .fast     (fast)
  );

  save_bank u_save (
    .clk    (clk),
    .rst    (rst),
    .save_en(fast),
    .flg_in (flg_q),
    .pc_in  (pc_in),
    .vct_we (vct_we),
    .vct_in (vct_wdata),
    .svf    (svf_o),
    .svp    (svp_o),
    .vct    (vct)
  );

  assign take = (src != SRC_NONE);

  // flag word next-state: restore > take > software interrupt > datapath write
  always_comb begin
    flg_d = flg_q;
    if (restore) begin
      flg_d = svf_o & ~RSV_MASK;
    end else if (take) begin
      flg_d[B_IEN] = 1'b0;
      flg_d[B_USP] = 1'b0;
      if (src == SRC_STEP) flg_d[B_DBG] = 1'b0;
    end else if (swi_take) begin
      if (int'(swi_num) < SWI_LIM) flg_d[B_USP] = 1'b0;
    end else if (flg_we) begin
      flg_d = flg_wdata & ~RSV_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q          <= '0;
      take_o         <= 1'b0;
      take_kind_o    <= 2'd0;
      fast_o         <= 1'b0;
      jump_o         <= '0;
      pc_load_o      <= 1'b0;
      pc_load_addr_o <= '0;
    end else begin
      flg_q       <= flg_d;
      take_o      <= take;
      take_kind_o <= src;
      fast_o      <= fast;
      pc_load_o   <= restore;
      if (fast)    jump_o         <= vct;
      if (restore) pc_load_addr_o <= svp_o;
    end
  end

  assign flg_o = flg_q;

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (flg_q & RSV_MASK) == '0);

  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (rst)
    take_o && take_kind_o == SRC_MASK |->
      $past(flg_q[B_IEN]) && ($past(irq_lvl) > $past(flg_q[B_IPL +: IPL_W])));

  assert_take_clears_R4: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !flg_q[B_IEN] && !flg_q[B_USP] && take_kind_o != SRC_NONE);

  assert_step_clears_R5: assert property (@(posedge clk) disable iff (rst)
    take_o && take_kind_o == SRC_STEP |-> !flg_q[B_DBG]);

  assert_order_R7: assert property (@(posedge clk) disable iff (rst)
    take_o && take_kind_o == SRC_MASK |-> !$past(nmi_pend) && !$past(flg_q[B_DBG]));

  assert_fast_save_R9: assert property (@(posedge clk) disable iff (rst)
    fast_o |-> svf_o == $past(flg_q) && svp_o == $past(pc_in) && take_kind_o == SRC_MASK);

  assert_restore_R10: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |-> flg_q == ($past(svf_o) & ~RSV_MASK) && !take_o
                 && pc_load_addr_o == $past(svp_o));
endmodule

// File: tb/intr_accept_unit_test.sv
module intr_accept_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_end, irq_req, irq_fast, nmi_pin, swi_take, flg_we, vct_we, restore;
  logic [2:0]  irq_lvl;
  logic [5:0]  swi_num;
  logic [15:0] flg_wdata;
  logic [23:0] pc_in, vct_wdata;

  logic [15:0] flg_o, svf_o;
  logic        take_o, fast_o, pc_load_o;
  logic [1:0]  take_kind_o;
  logic [23:0] jump_o, svp_o, pc_load_addr_o;

  always #2 clk = ~clk;

  intr_accept_unit uut (
    .clk(clk), .rst(rst), .instr_end(instr_end), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .irq_fast(irq_fast), .nmi_pin(nmi_pin), .swi_take(swi_take), .swi_num(swi_num),
    .flg_we(flg_we), .flg_wdata(flg_wdata), .pc_in(pc_in), .vct_we(vct_we),
    .vct_wdata(vct_wdata), .restore(restore), .flg_o(flg_o), .take_o(take_o),
    .take_kind_o(take_kind_o), .fast_o(fast_o), .jump_o(jump_o), .svf_o(svf_o),
    .svp_o(svp_o), .pc_load_o(pc_load_o), .pc_load_addr_o(pc_load_addr_o)
  );

  int vecs = 0;
  int bad  = 0;

  // reference state, derived from the requirements
  logic [15:0] m_flg = '0, m_svf = '0;
  logic [23:0] m_svp = '0, m_vct = '0, m_jump = '0, m_pcl = '0;
  logic        m_nmi = 1'b0;

  function automatic logic [1:0] pick_src(input logic [15:0] f, input logic pend);
    if (!instr_end || restore) return 2'd0;
    if (pend)    return 2'd3;
    if (f[1])    return 2'd2;
    if (irq_req && f[6] && (irq_lvl > f[14:12])) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [15:0] next_flg(input logic [15:0] f, input logic [1:0] k);
    logic [15:0] n = f;
    if (restore)              n = m_svf & 16'h70FF;
    else if (k != 2'd0) begin
      n[6] = 1'b0; n[7] = 1'b0;
      if (k == 2'd2) n[1] = 1'b0;
    end else if (swi_take) begin
      if (swi_num < 6'd32) n[7] = 1'b0;
    end else if (flg_we)     n = flg_wdata & 16'h70FF;
    return n;
  endfunction

  task automatic idle();
    instr_end = 0; irq_req = 0; irq_lvl = 0; irq_fast = 0; swi_take = 0; swi_num = 0;
    flg_we = 0; flg_wdata = 0; vct_we = 0; vct_wdata = 0; restore = 0;
  endtask

  task automatic apply(input string req);
    logic [1:0]  k;
    logic        fs, e_pcl;
    logic [15:0] nf;
    k     = pick_src(m_flg, m_nmi);
    fs    = (k == 2'd1) && irq_fast;
    nf    = next_flg(m_flg, k);
    e_pcl = restore;
    if (restore) m_pcl = m_svp;
    if (fs) begin
      m_jump = m_vct;
      m_svf  = m_flg;
      m_svp  = pc_in;
    end
    if (vct_we) m_vct = vct_wdata;
    if (k == 2'd3) m_nmi = 1'b0;
    m_flg = nf;
    @(posedge clk);
    @(negedge clk);
    vecs++;
    if (flg_o !== m_flg || take_o !== (k != 2'd0) || take_kind_o !== k || fast_o !== fs ||
        jump_o !== m_jump || svf_o !== m_svf || svp_o !== m_svp || pc_load_o !== e_pcl ||
        pc_load_addr_o !== m_pcl) begin
      bad++;
      $display("FAIL %s: flg=%h/%h take=%b/%b kind=%0d/%0d fast=%b/%b jump=%h/%h svf=%h/%h svp=%h/%h pcl=%b/%b addr=%h/%h",
               req, flg_o, m_flg, take_o, (k != 2'd0), take_kind_o, k, fast_o, fs,
               jump_o, m_jump, svf_o, m_svf, svp_o, m_svp, pc_load_o, e_pcl,
               pc_load_addr_o, m_pcl);
    end
  endtask

  task automatic wr(input logic [15:0] v, input string req);
    idle(); flg_we = 1; flg_wdata = v; apply(req); idle();
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    nmi_pin = 1; pc_in = 24'h000100;
    // R1: reset holds everything at zero even with a write presented
    flg_we = 1; flg_wdata = 16'hFFFF;
    repeat (3) @(negedge clk);
    vecs++;
    if (flg_o !== 0 || take_o !== 0 || fast_o !== 0 || svf_o !== 0 || svp_o !== 0 ||
        jump_o !== 0 || pc_load_o !== 0 || pc_load_addr_o !== 0 || take_kind_o !== 0) begin
      bad++;
      $display("FAIL R1: flg=%h take=%b fast=%b svf=%h expected all zero", flg_o, take_o, fast_o, svf_o);
    end
    rst = 0; idle();

    wr(16'hFFFF, "R2");                              // reserved bits drop -> 70FF
    wr(16'h3040, "R3");                              // I=1, level 3
    irq_req = 1; irq_lvl = 3; instr_end = 1; apply("R3 equal level"); idle();
    irq_req = 1; irq_lvl = 4; instr_end = 0; apply("R3 no boundary"); idle();
    wr(16'h30C5, "R4");
    irq_req = 1; irq_lvl = 4; instr_end = 1; apply("R4 take clears I,U"); idle();
    wr(16'h0005, "R3");
    irq_req = 1; irq_lvl = 7; instr_end = 1; apply("R3 disabled"); idle();
    wr(16'h0042, "R5");
    irq_req = 1; irq_lvl = 7; instr_end = 1; apply("R5 single-step"); idle();
    wr(16'h0080, "R8");
    swi_take = 1; swi_num = 31; apply("R8 num 31"); idle();
    wr(16'h0080, "R8");
    swi_take = 1; swi_num = 32; apply("R8 num 32"); idle();
    wr(16'h0040, "R11");
    irq_req = 1; irq_lvl = 1; instr_end = 1; flg_we = 1; flg_wdata = 16'hFFFF;
    apply("R11 take beats write"); idle();

    vct_we = 1; vct_wdata = 24'hABCDE1; apply("R9 vector load"); idle();
    wr(16'h20C1, "R9");
    pc_in = 24'h123456; irq_req = 1; irq_fast = 1; irq_lvl = 5; instr_end = 1;
    apply("R9 fast take"); idle();
    restore = 1; instr_end = 1; irq_req = 1; irq_lvl = 7; apply("R10 restore"); idle();

    wr(16'h0042, "R6");
    nmi_pin = 0;
    repeat (4) apply("R6 sync wait");
    m_nmi = 1'b1;
    irq_req = 1; irq_lvl = 7; instr_end = 1; apply("R7 pin first"); idle();
    instr_end = 1; irq_req = 1; irq_lvl = 7; apply("R7 step next"); idle();
    nmi_pin = 1;
    repeat (4) apply("R6 rise ignored");
    instr_end = 1; apply("R6 no take on rise"); idle();
    nmi_pin = 0;
    repeat (4) apply("R6 sync wait");
    m_nmi = 1'b1;
    instr_end = 1; apply("R6 unmaskable"); idle();
    nmi_pin = 1;
    repeat (4) apply("R6 settle");

    for (int i = 0; i < 3000; i++) begin
      idle();
      instr_end = ($urandom % 2) == 0;
      irq_req   = ($urandom % 3) != 0;
      irq_lvl   = 3'($urandom);
      irq_fast  = ($urandom % 2) == 0;
      swi_take  = ($urandom % 8) == 0;
      swi_num   = 6'($urandom);
      flg_we    = ($urandom % 3) == 0;
      flg_wdata = 16'($urandom);
      vct_we    = ($urandom % 8) == 0;
      vct_wdata = 24'($urandom);
      restore   = ($urandom % 16) == 0;
      pc_in     = 24'($urandom);
      apply("R3/R4/R9/R10/R11 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule